// File: doc/BRIEF.md
# Debounced Wake-up Input Detector

This block watches a bank of external wake-up lines clocked by the slow clock. Each line is qualified by its own enable bit and its own polarity bit. While the enabled lines are considered, their OR forms one "something is asserting" condition. A single shared debounce timer measures how long that condition has been continuously true. When the time set by a 3-bit period code is reached, the block issues a one-cycle wake-up request. In that same cycle it records which enabled lines were at their active level, and it sets a sticky flag that stays up until status is read.

The lines are taken as already synchronous to the slow clock. Register decode and the power sequencing that follows a wake-up sit outside this block. Software-facing fields reach the block as plain input vectors, and a one-cycle read strobe marks each status read.

Top module: `wkup_debounce`

## Requirements
- R1: Line i counts as asserting only when en_mask[i] is 1 and wk_in[i] equals lvl_mask[i]. A polarity bit of 1 selects active-high and 0 selects active-low.
- R2: A line whose en_mask bit is 0 never produces a wake-up request, whatever its level.
- R3: dbc_sel sets the number L of consecutive slow-clock edges at which some enabled line must be asserting: 0 gives 1, 1 gives 3, 2 gives 32, 3 gives 512, 4 gives 4096, 5 gives 32768, and 6 and 7 behave like 0. wake_req is high for exactly the one cycle that follows the L-th such edge.
- R4: If no enabled line is asserting at any edge before L is reached, the count restarts from zero.
- R5: When a request fires, wake_snap[i] is loaded with 1 for each line that is enabled and asserting at that edge, and with 0 for every other line. wake_snap then holds this value until the next request.
- R6: wake_flag goes to 1 on every request and stays there until an sts_rd strobe clears it. If a request and a read fall in the same cycle, the flag stays 1.
- R7: After a request, no further request occurs until the OR of the enabled asserting lines has been false at one edge or more and a full new period of L edges has then passed.
- R8: While rst_n is low, wake_req, wake_flag and wake_snap are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wk_in | input | N_IN | Wake-up lines, synchronous to clk |
| en_mask | input | N_IN | Per-line enable |
| lvl_mask | input | N_IN | Per-line active level (1 = high) |
| dbc_sel | input | 3 | Debounce period code |
| sts_rd | input | 1 | One-cycle status read strobe |
| wake_req | output | 1 | One-cycle wake-up request |
| wake_flag | output | 1 | Sticky wake-up flag |
| wake_snap | output | N_IN | Lines asserting at the trigger edge |

## Verification
Two situations are hardest to reach from the ports. The first is the read strobe landing in exactly the same cycle as a trigger. The bench reaches it with code 0, where the trigger lands on the first edge: it raises sts_rd in the same half-cycle that the line is asserted, so the flag must survive the clear. The second is a count that is interrupted one short of its target. With code 1 the bench holds a line active for two edges, drops it for one edge and then measures a fresh three-edge latency. The long codes are reached by holding one line steady for up to 32768 cycles.

// File: rtl/wkup_pkg.sv
package wkup_pkg;

  localparam int unsigned DBC_CNT_W = 16;

  typedef logic [DBC_CNT_W-1:0] dbc_cnt_t;

  // Number of consecutive asserting edges required for a debounce code.
  function automatic dbc_cnt_t dbc_len(input logic [2:0] code);
    dbc_cnt_t len;
    case (code)
      3'd1:    len = dbc_cnt_t'(3);
      3'd2:    len = dbc_cnt_t'(32);
      3'd3:    len = dbc_cnt_t'(512);
      3'd4:    len = dbc_cnt_t'(4096);
      3'd5:    len = dbc_cnt_t'(32768);
      default: len = dbc_cnt_t'(1);
    endcase
    return len;
  endfunction

endpackage

// File: rtl/wkup_level_map.sv
module wkup_level_map #(
  parameter int unsigned N_IN = 16
) (
  input  logic [N_IN-1:0] wk_in,
  input  logic [N_IN-1:0] en_mask,
  input  logic [N_IN-1:0] lvl_mask,
  output logic [N_IN-1:0] act_vec,
  output logic            any_act
);

  // Per-line qualification: enabled and at the programmed level.
  for (genvar g = 0; g < N_IN; g++) begin : g_line
    assign act_vec[g] = en_mask[g] & ~(wk_in[g] ^ lvl_mask[g]);
  end

  assign any_act = |act_vec;

endmodule

// File: rtl/wkup_dbc_timer.sv
module wkup_dbc_timer
  import wkup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any_act,
  input  logic [2:0] dbc_sel,
  output logic       trig
);

  dbc_cnt_t cnt_q, cnt_d;
  logic     cnt_en;
  logic     fired_q, fired_d;
  dbc_cnt_t len_m1;

  assign len_m1 = dbc_len(dbc_sel) - dbc_cnt_t'(1);

  // Next-state logic
  always_comb begin
    trig   = any_act & ~fired_q & (cnt_q >= len_m1);
    cnt_en = any_act | (cnt_q != '0);
    if (!any_act) begin
      cnt_d = '0;
    end else if (cnt_q != '1) begin
      cnt_d = cnt_q + dbc_cnt_t'(1);
    end else begin
      cnt_d = cnt_q;
    end
    fired_d = any_act & (fired_q | trig);
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired_q <= 1'b0;
    end else begin
      fired_q <= fired_d;
    end
  end

endmodule

// File: rtl/wkup_status.sv
module wkup_status #(
  parameter int unsigned N_IN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trig,
  input  logic [N_IN-1:0] act_vec,
  input  logic            sts_rd,
  output logic            wake_req,
  output logic            wake_flag,
  output logic [N_IN-1:0] wake_snap
);

  logic            flag_d;
  logic            flag_en;

  always_comb begin
    flag_en = trig | sts_rd;
    flag_d  = trig | (wake_flag & ~sts_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_req <= 1'b0;
    end else begin
      wake_req <= trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
    end else if (flag_en) begin
      wake_flag <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_snap <= '0;
    end else if (trig) begin
      wake_snap <= act_vec;
    end
  end

endmodule

// File: rtl/wkup_debounce.sv
module wkup_debounce #(
  parameter int unsigned N_IN = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] wk_in,
  input  logic [N_IN-1:0] en_mask,
  input  logic [N_IN-1:0] lvl_mask,
  input  logic [2:0]      dbc_sel,
  input  logic            sts_rd,
  output logic            wake_req,
  output logic            wake_flag,
  output logic [N_IN-1:0] wake_snap
);

  logic [N_IN-1:0] act_vec;
  logic            any_act;
  logic            trig;

  wkup_level_map #(.N_IN(N_IN)) u_map (
    .wk_in    (wk_in),
    .en_mask  (en_mask),
    .lvl_mask (lvl_mask),
    .act_vec  (act_vec),
    .any_act  (any_act)
  );

  wkup_dbc_timer u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_act (any_act),
    .dbc_sel (dbc_sel),
    .trig    (trig)
  );

  wkup_status #(.N_IN(N_IN)) u_sts (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .act_vec   (act_vec),
    .sts_rd    (sts_rd),
    .wake_req  (wake_req),
    .wake_flag (wake_flag),
    .wake_snap (wake_snap)
  );

endmodule

// File: rtl/wkup_debounce_chk.sv
module wkup_debounce_chk #(
  parameter int unsigned N_IN = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] en_mask,
  input logic            sts_rd,
  input logic            wake_req,
  input logic            wake_flag,
  input logic [N_IN-1:0] wake_snap
);

  // R2 / R5: captured lines were enabled at the trigger edge
  p_snap_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> ((wake_snap & ~$past(en_mask)) == '0));

  // R5: a request always records at least one asserting line
  p_snap_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> (wake_snap != '0));

  // R6: request implies flag
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> wake_flag);

  // R6: flag holds without a read
  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wake_flag) && !$past(sts_rd)) |-> wake_flag);

  // R6: read clears the flag unless a request coincides
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sts_rd) && !wake_req) |-> !wake_flag);

  // R7: requests never come back to back
  p_no_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);

  // R5: snapshot only changes on a request
  p_snap_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_req |-> $stable(wake_snap));

endmodule

bind wkup_debounce wkup_debounce_chk #(.N_IN(N_IN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en_mask   (en_mask),
  .sts_rd    (sts_rd),
  .wake_req  (wake_req),
  .wake_flag (wake_flag),
  .wake_snap (wake_snap)
);

// File: tb/wkup_debounce_tb.sv
module wkup_debounce_tb;

  localparam int unsigned N = 16;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] wk_in, en_mask, lvl_mask;
  logic [2:0]   dbc_sel;
  logic         sts_rd;
  logic         wake_req, wake_flag;
  logic [N-1:0] wake_snap;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  wkup_debounce #(.N_IN(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .wk_in(wk_in), .en_mask(en_mask),
    .lvl_mask(lvl_mask), .dbc_sel(dbc_sel), .sts_rd(sts_rd),
    .wake_req(wake_req), .wake_flag(wake_flag), .wake_snap(wake_snap)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [2:0] c);
    case (c)
      3'd1: return 3;
      3'd2: return 32;
      3'd3: return 512;
      3'd4: return 4096;
      3'd5: return 32768;
      default: return 1;
    endcase
  endfunction

  // Drop all enables so the debouncer re-arms, then clear the flag.
  task automatic idle();
    en_mask = '0;
    sts_rd  = 1'b0;
    @(negedge clk);
    @(negedge clk);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
  endtask

  task automatic measure(output int lat);
    lat = 0;
    for (int k = 1; k <= 40000; k++) begin
      @(negedge clk);
      if (wake_req) begin
        lat = k;
        break;
      end
    end
  endtask

  task automatic count_pulses(input int n, output int p);
    p = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (wake_req) p++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int lat, p;
    logic [N-1:0] expv;
    rst_n = 1'b0; wk_in = '0; en_mask = '0; lvl_mask = '0;
    dbc_sel = 3'd0; sts_rd = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(wake_req == 1'b0, "R8 req", wake_req, 0);
    chk(wake_flag == 1'b0, "R8 flag", wake_flag, 0);
    chk(wake_snap == '0, "R8 snap", wake_snap, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: latency for every code
    for (int c = 0; c < 8; c++) begin
      idle();
      dbc_sel = 3'(c);
      lvl_mask = 16'h0001; wk_in = 16'h0001; en_mask = 16'h0001;
      measure(lat);
      chk(lat == exp_len(3'(c)), "R3 latency", lat, exp_len(3'(c)));
      @(negedge clk);
      chk(wake_req == 1'b0, "R3 one-cycle pulse", wake_req, 0);
    end

    // R1 / R5: each line, each polarity, with disabled neighbours asserting
    dbc_sel = 3'd0;
    for (int i = 0; i < N; i++) begin
      for (int pol = 0; pol < 2; pol++) begin
        idle();
        lvl_mask = pol[0] ? 16'hA5C3 | (16'h1 << i) : 16'hA5C3 & ~(16'h1 << i);
        wk_in    = lvl_mask;
        en_mask  = 16'h1 << i;
        measure(lat);
        chk(lat == 1, "R1 polarity latency", lat, 1);
        chk(wake_snap == (16'h1 << i), "R5 single snap", wake_snap, 16'h1 << i);
        chk(wake_flag == 1'b1, "R6 flag after wake", wake_flag, 1);
        // R1: inactive level must not assert
        idle();
        wk_in   = ~lvl_mask;
        en_mask = 16'h1 << i;
        count_pulses(4, p);
        chk(p == 0 && wake_flag == 1'b0, "R1 inactive level", p, 0);
      end
    end

    // R2: all disabled, all at active level
    idle();
    lvl_mask = 16'h3C3C; wk_in = 16'h3C3C; en_mask = '0;
    count_pulses(50, p);
    chk(p == 0, "R2 disabled pulses", p, 0);
    chk(wake_flag == 1'b0, "R2 disabled flag", wake_flag, 0);

    // R4: interrupted count restarts
    idle();
    dbc_sel = 3'd1; lvl_mask = 16'h0010; en_mask = 16'h0010;
    wk_in = 16'h0010;
    count_pulses(2, p);
    wk_in = 16'h0000;
    @(negedge clk);
    chk(p == 0 && wake_req == 1'b0, "R4 no early pulse", p, 0);
    wk_in = 16'h0010;
    measure(lat);
    chk(lat == 3, "R4 restart latency", lat, 3);

    // R5: multi-line snapshot, held while inputs change
    idle();
    dbc_sel = 3'd0; lvl_mask = 16'h0F0F; wk_in = 16'h0F33;
    en_mask = 16'h00FF;
    expv = en_mask & ~(wk_in ^ lvl_mask);
    measure(lat);
    chk(wake_snap == expv, "R5 multi snap", wake_snap, expv);
    wk_in = 16'h0F0F;
    count_pulses(5, p);
    chk(p == 0 && wake_snap == expv, "R5 snap held", wake_snap, expv);

    // R6: sticky until read
    chk(wake_flag == 1'b1, "R6 sticky", wake_flag, 1);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    chk(wake_flag == 1'b0, "R6 read clears", wake_flag, 0);

    // R6: read coincides with trigger
    idle();
    dbc_sel = 3'd0; lvl_mask = 16'h8000; wk_in = 16'h8000;
    en_mask = 16'h8000; sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    chk(wake_req == 1'b1, "R6 coincident req", wake_req, 1);
    chk(wake_flag == 1'b1, "R6 coincident flag", wake_flag, 1);
    sts_rd = 1'b1;
    @(negedge clk);
    sts_rd = 1'b0;
    chk(wake_flag == 1'b0, "R6 later read", wake_flag, 0);

    // R7: one request per active episode, re-arm after a gap
    idle();
    dbc_sel = 3'd0; lvl_mask = 16'h0002; wk_in = 16'h0002; en_mask = 16'h0002;
    count_pulses(20, p);
    chk(p == 1, "R7 single pulse", p, 1);
    wk_in = 16'h0000;
    @(negedge clk);
    wk_in = 16'h0002;
    count_pulses(6, p);
    chk(p == 1, "R7 re-armed", p, 1);
    idle();
    dbc_sel = 3'd2; en_mask = 16'h0002; wk_in = 16'h0002;
    measure(lat);
    wk_in = 16'h0000;
    @(negedge clk);
    wk_in = 16'h0002;
    measure(lat);
    chk(lat == 32, "R7 full new period", lat, 32);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule